// File: doc/BRIEF.md
# MDIO management master controller

This block is the master side of a two-wire management bus for Ethernet PHYs. Software controls it through one 32-bit command word. It first writes the address, opcode and data fields with the go bit clear. It then writes the same word again with the go bit set. The block generates the management clock, sends a preamble and one complete frame, and then hands the bus back. Bit 31 of the read-back word stays high for as long as the frame is in progress.

The framing style is selected from the command word. A start code of 01 gives the short frame, which carries a PHY address and a register address. A start code of 00 gives the extended frame, which carries a port address and a device address. An extended register access needs two transactions: an address transaction that carries the 16-bit register number, then the read or write itself. On a read, the master releases the data line for the turnaround and data bits. It samples the 16 returned bits and places them in the low half of the command word.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the read-back word is zero, the management clock is low and the output enable is low.
- R2: If a write with bit 31 set arrives while bit 31 reads 0, a frame starts. Bit 31 reads 1 from the next cycle for exactly 65*CLK_DIV cycles, then reads 0.
- R3: If a write with bit 31 clear arrives while idle, bits 30:0 are stored and can be read back. No frame starts: bit 31 stays 0, the management clock stays low and the output enable stays low.
- R4: A write that arrives while bit 31 reads 1 is ignored. Neither the stored word nor the frame in progress changes.
- R5: The management clock runs only while busy. Its period is CLK_DIV system cycles: low for the first half of each bit period and high for the second half. It is low whenever bit 31 reads 0.
- R6: Every frame opens with 32 bit periods of logic 1, driven with the output enable high.
- R7: Next come the start code (bits 17:16), the opcode (bits 19:18), the port/PHY address (bits 24:20) and the register/device address (bits 29:25), each sent most significant bit first. Start code 01 means short frame and 00 means extended frame. Opcodes for the short frame: 10 read, 01 write. Opcodes for the extended frame: 00 address, 01 write, 11 read.
- R8: When opcode bit 19 is 0 (a write or an address transaction), the master drives the turnaround as 1 then 0. It then drives bits 15:0, most significant bit first.
- R9: When opcode bit 19 is 1 (a read), the output enable is low for the two turnaround bits and the 16 data bits. The line is sampled at each rising clock edge of the data bits, most significant bit first. At completion the captured value replaces bits 15:0 and bits 30:16 keep their values.
- R10: After the 64 frame bits come one more clock period with the output enable low. Bit 31 clears at the end of that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word being written |
| cmd_rdata | output | 32 | Read-back word: bit 31 busy, fields, captured data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
All timing counts from the clock edge that samples the write strobe, cycle 0. Busy is visible in cycle 0. Bit k of the frame spans cycles k*CLK_DIV to k*CLK_DIV+CLK_DIV-1, and the clock is high in the second half of that span. The busy flag and any read data change together at cycle 65*CLK_DIV. The bench stamps each accepted command with a cycle counter. On every falling system clock edge it derives the bit index and phase from that counter, and compares the clock, enable, line value, busy flag and stored word against values built from the fields. The stand-in PHY drives the read data from the same counter, so every sample falls inside the bit that the requirement names.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Command word layout
  typedef struct packed {
    logic        go;       // 31
    logic        spare;    // 30
    logic [4:0]  reg_dev;  // 29:25
    logic [4:0]  port;     // 24:20
    logic [1:0]  op;       // 19:18
    logic [1:0]  sof;      // 17:16
    logic [15:0] data;     // 15:0
  } mdio_cmd_t;

  localparam int unsigned HDR_BITS = 32;
  localparam int unsigned TA_POS   = 14;  // offset of turnaround inside header
  localparam int unsigned DAT_POS  = 16;  // offset of data inside header

  // Header bits sent after the preamble, MSB first
  function automatic logic [HDR_BITS-1:0] build_hdr(input mdio_cmd_t c);
    logic [1:0] ta;
    ta = c.op[1] ? 2'b00 : 2'b10;
    return {c.sof, c.op, c.port, c.reg_dev, ta, c.data};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST_V  = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] HALF_V  = CW'(HALF);
  localparam logic [CW-1:0] HALFM_V = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  always_comb begin
    cnt_d = '0;
    if (run) begin
      if (cnt_q == LAST_V) cnt_d = '0;
      else                 cnt_d = cnt_q + 1'b1;
    end
    mdc_d = (cnt_d >= HALF_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = run && (cnt_q == HALFM_V);
  assign fall_tick = run && (cnt_q == LAST_V);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [HDR_BITS-1:0] hdr,
  input  logic                is_read,
  input  logic                rise_tick,
  input  logic                fall_tick,
  input  logic                mdio_i,
  output logic                run,
  output logic                done,
  output logic                mdio_o,
  output logic                mdio_oe,
  output logic [15:0]         rd_data
);
  localparam int unsigned TOTAL = PRE_BITS + HDR_BITS;
  localparam int unsigned BW    = $clog2(TOTAL + 1);
  localparam logic [BW-1:0] TOT_V = BW'(TOTAL);
  localparam logic [BW-1:0] PRE_V = BW'(PRE_BITS);
  localparam logic [BW-1:0] TA_V  = BW'(PRE_BITS + TA_POS);
  localparam logic [BW-1:0] DAT_V = BW'(PRE_BITS + DAT_POS);

  logic                run_q, run_d;
  logic [BW-1:0]       bit_q, bit_d;
  logic [HDR_BITS-1:0] hdr_q, hdr_d;
  logic                rd_q, rd_d;
  logic [15:0]         cap_q, cap_d;
  logic [4:0]          pos;
  logic                hdr_bit;
  logic                in_data;

  assign pos     = 5'(bit_q - PRE_V);
  assign hdr_bit = hdr_q[5'd31 - pos];
  assign in_data = (bit_q >= DAT_V) && (bit_q < TOT_V);
  assign done    = run_q && fall_tick && (bit_q == TOT_V);

  always_comb begin
    run_d = run_q;
    bit_d = bit_q;
    hdr_d = hdr_q;
    rd_d  = rd_q;
    cap_d = cap_q;
    if (start && !run_q) begin
      run_d = 1'b1;
      bit_d = '0;
      hdr_d = hdr;
      rd_d  = is_read;
    end else if (run_q) begin
      if (rise_tick && rd_q && in_data) cap_d = {cap_q[14:0], mdio_i};
      if (done)           run_d = 1'b0;
      else if (fall_tick) bit_d = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      bit_q <= '0;
      hdr_q <= '0;
      rd_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      run_q <= run_d;
      bit_q <= bit_d;
      hdr_q <= hdr_d;
      rd_q  <= rd_d;
      cap_q <= cap_d;
    end
  end

  always_comb begin
    mdio_oe = run_q && (bit_q < TOT_V) && !(rd_q && (bit_q >= TA_V));
    if (!mdio_oe)            mdio_o = 1'b0;
    else if (bit_q < PRE_V)  mdio_o = 1'b1;
    else                     mdio_o = hdr_bit;
  end

  assign run     = run_q;
  assign rd_data = cap_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 4,
  parameter int unsigned PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]  sync_q;
  logic        rst_sync_n;
  logic [30:0] word_q, word_d;
  logic        busy, done, rise_tick, fall_tick, accept, start;
  logic        rd_pend_q, rd_pend_d;
  logic [15:0] rd_data;
  mdio_cmd_t   wcmd;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  assign wcmd   = mdio_cmd_t'(cmd_wdata);
  assign accept = cmd_wr && !busy;
  assign start  = accept && wcmd.go;

  always_comb begin
    word_d    = word_q;
    rd_pend_d = rd_pend_q;
    if (accept) begin
      word_d    = cmd_wdata[30:0];
      rd_pend_d = wcmd.go && wcmd.op[1];
    end else if (done) begin
      if (rd_pend_q) word_d[15:0] = rd_data;
      rd_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q    <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      word_q    <= word_d;
      rd_pend_q <= rd_pend_d;
    end
  end

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .hdr       (build_hdr(wcmd)),
    .is_read   (wcmd.op[1]),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .run       (busy),
    .done      (done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data)
  );

  assign cmd_rdata = {busy, word_q};

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] cmd_wdata,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_oe
);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rdata[31] && cmd_wdata[31]) |=> cmd_rdata[31]);

  // R3
  no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rdata[31] && !cmd_wdata[31]) |=>
      (!cmd_rdata[31] && (cmd_rdata[30:0] == $past(cmd_wdata[30:0]))));

  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_rdata[31]) |=> $stable(cmd_rdata[30:16]));

  // R5
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdata[31] |-> !mdc);

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rdata[31] |-> !mdio_oe);

  // R10
  tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_rdata[31]) |-> !$past(mdio_oe));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_wr    (cmd_wr),
  .cmd_wdata (cmd_wdata),
  .cmd_rdata (cmd_rdata),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int DIV  = 4;
  localparam int PRE  = 32;
  localparam int NB   = PRE + 32;
  localparam int HALF = DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr;
  logic [31:0] cmd_wdata;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  bit          exp_bits [NB];
  bit          exp_drv  [NB];
  logic [31:0] exp_reg;
  bit          m_active = 0;
  bit          m_read   = 0;
  int          start_cyc = 0;
  logic [15:0] rd_val = 16'h0;
  bit          cmp_en = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_master #(.CLK_DIV(DIV), .PRE_BITS(PRE)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] mk(input bit go, input logic [1:0] sof, input logic [1:0] op,
                                     input logic [4:0] port, input logic [4:0] rdev, input logic [15:0] d);
    return {go, 1'b0, rdev, port, op, sof, d};
  endfunction

  // expected frame from the field definitions in R6..R9
  task automatic build(input logic [31:0] w);
    logic [31:0] h;
    h = {w[17:16], w[19:18], w[24:20], w[29:25], (w[19] ? 2'b00 : 2'b10), w[15:0]};
    for (int i = 0; i < PRE; i++) begin exp_bits[i] = 1'b1; exp_drv[i] = 1'b1; end
    for (int j = 0; j < 32; j++) begin
      exp_bits[PRE+j] = h[31-j];
      exp_drv[PRE+j]  = !(w[19] && j >= 14);
    end
    m_read = w[19];
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(posedge clk); #1;
    if (!m_active) begin
      exp_reg = {1'b0, w[30:0]};
      if (w[31]) begin build(w); m_active = 1; start_cyc = cyc; end
    end
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_active);
  endtask

  // per-cycle comparison and stand-in PHY
  always @(negedge clk) begin
    if (cmp_en) begin
      int t, b, ph;
      bit e_mdc, e_oe, e_o, e_busy, ok;
      string tag;
      t = cyc - start_cyc;
      if (m_active && t == (NB + 1) * DIV) begin
        if (m_read) exp_reg[15:0] = rd_val;  // R9 completion
        m_active = 0;
      end
      b = t / DIV; ph = t % DIV;
      e_busy = m_active;
      e_mdc  = m_active && (ph >= HALF);
      e_oe   = m_active && (b < NB) && exp_drv[b < NB ? b : 0];
      e_o    = (b < NB) ? exp_bits[b < NB ? b : 0] : 1'b0;
      mdio_i = (m_active && m_read && b >= PRE + 16 && b < NB) ? rd_val[15 - (b - PRE - 16)] : 1'b1;
      ok = (mdc === e_mdc) && (mdio_oe === e_oe) && (cmd_rdata[31] === e_busy) &&
           (cmd_rdata[30:0] === exp_reg[30:0]) && (!e_oe || mdio_o === e_o);
      if (mdc !== e_mdc)                 tag = "R5 mdc";
      else if (cmd_rdata[31] !== e_busy) tag = "R2 busy";
      else if (mdio_oe !== e_oe || (e_oe && mdio_o !== e_o)) begin
        if (b < PRE)           tag = "R6 preamble";
        else if (b < PRE + 14) tag = "R7 header";
        else if (b >= NB)      tag = "R10 idle tail";
        else if (m_read)       tag = "R9 release";
        else                   tag = "R8 ta/data";
      end else tag = "R4 stored word";
      check(ok, tag, {e_busy ? 1'b0 : 1'b0, 27'd0, cmd_rdata[31], mdc, mdio_oe, mdio_o},
                     {28'd0, e_busy, e_mdc, e_oe, e_o});
      if (!ok) $display("     word act %h exp %h", cmd_rdata, {e_busy, exp_reg[30:0]});
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] wa;
    cmd_wr = 1'b0; cmd_wdata = '0; mdio_i = 1'b1; exp_reg = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(cmd_rdata == 32'd0 && !mdc && !mdio_oe, "R1 in reset", {cmd_rdata[31:3], mdc, mdio_oe, 1'b0}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_rdata == 32'd0 && !mdc && !mdio_oe, "R1 after reset", cmd_rdata, 32'd0);
    cmp_en = 1;

    // R3 fields without go
    wa = mk(1'b0, 2'b01, 2'b01, 5'd5, 5'd3, 16'hA5C3);
    issue(wa);
    repeat (12) @(negedge clk);
    check(cmd_rdata == {1'b0, wa[30:0]} && !mdc, "R3 stored no start", cmd_rdata, {1'b0, wa[30:0]});

    // R2 short-frame write, then go
    issue(wa | 32'h8000_0000);
    check(cmd_rdata[31] === 1'b1, "R2 busy after go", cmd_rdata, {1'b1, wa[30:0]});
    wait_idle();
    check(cmd_rdata == {1'b0, wa[30:0]}, "R8 write keeps data", cmd_rdata, {1'b0, wa[30:0]});

    // R9 short-frame read
    rd_val = 16'h1234;
    issue(mk(1'b1, 2'b01, 2'b10, 5'd31, 5'd17, 16'h0000));
    wait_idle();
    check(cmd_rdata[15:0] == 16'h1234, "R9 short read data", {16'd0, cmd_rdata[15:0]}, 32'h1234);
    check(cmd_rdata[30:16] == {1'b0, 5'd17, 5'd31, 2'b10, 2'b01}, "R9 upper bits kept",
          {17'd0, cmd_rdata[30:16]}, {17'd0, 1'b0, 5'd17, 5'd31, 2'b10, 2'b01});

    // R4 write during busy ignored
    wa = mk(1'b1, 2'b01, 2'b01, 5'd9, 5'd2, 16'h0F0F);
    issue(wa);
    repeat (30) @(negedge clk);
    issue(mk(1'b1, 2'b00, 2'b11, 5'd1, 5'd1, 16'hFFFF));
    wait_idle();
    check(cmd_rdata == {1'b0, wa[30:0]}, "R4 ignored while busy", cmd_rdata, {1'b0, wa[30:0]});

    // R7 extended: address, write, read; back to back
    issue(mk(1'b1, 2'b00, 2'b00, 5'd4, 5'd30, 16'h8001));
    wait_idle();
    check(!cmd_rdata[31] && cmd_rdata[15:0] == 16'h8001, "R7 ext address", cmd_rdata, 32'h0000_8001);
    issue(mk(1'b1, 2'b00, 2'b01, 5'd4, 5'd30, 16'h5AA5));
    wait_idle();
    check(cmd_rdata[15:0] == 16'h5AA5, "R8 ext write data", {16'd0, cmd_rdata[15:0]}, 32'h5AA5);
    rd_val = 16'hBEEF;
    issue(mk(1'b1, 2'b00, 2'b11, 5'd4, 5'd30, 16'h0000));
    wait_idle();
    check(cmd_rdata[15:0] == 16'hBEEF, "R9 ext read data", {16'd0, cmd_rdata[15:0]}, 32'hBEEF);
    // R2 immediate restart once idle
    rd_val = 16'h8001;
    issue(mk(1'b1, 2'b01, 2'b10, 5'd0, 5'd0, 16'h0000));
    check(cmd_rdata[31] === 1'b1, "R2 restart", cmd_rdata, 32'h8000_0000);
    wait_idle();
    check(cmd_rdata[15:0] == 16'h8001, "R9 read edge bits", {16'd0, cmd_rdata[15:0]}, 32'h8001);
    repeat (5) @(negedge clk);
    check(!mdc && !mdio_oe, "R10 idle after frame", {30'd0, mdc, mdio_oe}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule